// File: doc/BRIEF.md
# Seven-to-One Parallel Video Serializer

This block turns a 21-bit parallel pixel word into three serial data lanes and one forwarded clock lane. It runs entirely on a fast bit clock at seven times the pixel rate. The incoming pixel clock is treated as a sampled level. A selectable edge of that level copies the parallel word into a holding register. A one-cycle frame strobe then starts the slot sequence. After that, every seventh fast cycle hands the held word to the lane shift registers, with no idle slot between words.

The 21 bits form three 7-bit groups, one per data lane. In a typical display link the 18 colour bits and the three timing bits (horizontal sync, vertical sync and one control bit) are spread over these groups. Inside each pixel period the lanes emit their bits in a fixed, non-sequential order. The fourth lane carries a pixel-rate clock shape that is high for four slots and low for three, and its rising step lines up with the first data slot. An active-low power-down input silences every lane and parks the sequencer until a new frame strobe arrives. Supported pixel rates are 20 to 85 MHz, so the bit clock runs from 140 to 595 MHz.

Top module: `vser_top`

## Requirements
- R1: After reset all four lane outputs are low, and they stay low until the first frame strobe is sampled with power-down released.
- R2: Data lane k (k = 0, 1, 2 on `lane_data[k]`) serializes only the bits `pix_word[7k+6:7k]`.
- R3: In the seven fast cycles of one pixel period, a data lane presents, from its first slot to its last, group bits 1, 0, 6, 5, 4, 3, 2.
- R4: `lane_clk` is high in slots 0 to 3 and low in slots 4 to 6 of every pixel period, where slot 0 is the slot that carries group bit 1 on the data lanes.
- R5: Once started, the sequencer loads the held word again right after slot 6, so periods follow each other with no gap and with no further strobe.
- R6: With `cap_fall` = 0 the word is captured on a 0-to-1 step of the sampled `pclk_in`; with `cap_fall` = 1 it is captured on a 1-to-0 step. Each period sends the word from the latest such capture before its load.
- R7: While `pd_n` is low, all lanes go low one cycle later, strobes and pixel-clock edges are ignored, and after `pd_n` returns high the lanes remain low until a new frame strobe.
- R8: A frame strobe sampled in the middle of a period restarts the sequence at slot 0 with the held word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down |
| cap_fall | input | 1 | Static capture-edge select: 0 rising, 1 falling |
| pclk_in | input | 1 | Pixel clock level, sampled on `clk` |
| pix_word | input | 21 | Parallel pixel word, three 7-bit groups |
| frame_stb | input | 1 | One-cycle strobe that starts or realigns the slot sequence |
| lane_data | output | 3 | Serial data lanes, bit k is lane k |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
The pixel words include walking-one patterns. A single set bit shows on exactly one lane in exactly one slot, so a swapped lane group (R2) cannot be confused with a wrong slot order (R3). Random words then test each period's handover and the no-gap reload. The same random traffic is repeated with falling-edge capture: because the word changes between the two edges, a design that picks the wrong edge sends the previous word. Strobes placed mid-period and during power-down separate a correct restart or ignore from a sequencer that drifts or wakes up by itself.

// File: rtl/vser_pkg.sv
package vser_pkg;

    localparam int unsigned DEF_LANE_BITS = 7;
    localparam int unsigned DEF_DATA_LANES = 3;

    typedef enum logic {
        CAP_RISE = 1'b0,
        CAP_FALL = 1'b1
    } cap_edge_e;

    // Group bit sent in a given slot: slot 0 takes bit 1, then bits
    // descend from 0 wrapping through the top of the group.
    function automatic int unsigned src_bit(int unsigned pos, int unsigned bits);
        return (bits + 1 - pos) % bits;
    endfunction

    // Forwarded clock shape, LSB is slot 0: the first ceil(bits/2) slots high.
    function automatic logic [31:0] clk_shape(int unsigned bits);
        logic [31:0] pat;
        pat = '0;
        for (int unsigned i = 0; i < bits; i++) begin
            pat[i] = (i < (bits + 1) / 2);
        end
        return pat;
    endfunction

endpackage

// File: rtl/vser_capture.sv
module vser_capture
    import vser_pkg::*;
#(
    parameter int unsigned WORD_BITS = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pd_n,
    input  logic                 cap_fall,
    input  logic                 pclk_in,
    input  logic [WORD_BITS-1:0] word_in,
    output logic [WORD_BITS-1:0] held_word
);

    logic      pclk_q;
    logic      rise_seen;
    logic      fall_seen;
    logic      take;
    cap_edge_e edge_sel;

    assign edge_sel  = cap_edge_e'(cap_fall);
    assign rise_seen = pclk_in & ~pclk_q;
    assign fall_seen = pclk_q & ~pclk_in;

    always_comb begin
        unique case (edge_sel)
            CAP_RISE: take = pd_n & rise_seen;
            CAP_FALL: take = pd_n & fall_seen;
            default:  take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q    <= 1'b0;
            held_word <= '0;
        end else begin
            pclk_q <= pclk_in;
            if (take) begin
                held_word <= word_in;
            end
        end
    end

endmodule

// File: rtl/vser_seq.sv
module vser_seq #(
    parameter int unsigned LANE_BITS = 7,
    localparam int unsigned SLOT_W = $clog2(LANE_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              frame_stb,
    output logic              load,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANE_BITS - 1);

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
    } seq_state_t;

    seq_state_t cur_s;
    seq_state_t nxt_s;

    assign load = pd_n & (frame_stb | (cur_s.run & (cur_s.slot == LAST_SLOT)));
    assign slot = cur_s.slot;

    always_comb begin
        nxt_s = cur_s;
        if (!pd_n) begin
            nxt_s.run  = 1'b0;
            nxt_s.slot = '0;
        end else if (load) begin
            nxt_s.run  = 1'b1;
            nxt_s.slot = '0;
        end else if (cur_s.run) begin
            nxt_s.slot = cur_s.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_s <= '0;
        end else begin
            cur_s <= nxt_s;
        end
    end

endmodule

// File: rtl/vser_lane.sv
module vser_lane
    import vser_pkg::*;
#(
    parameter int unsigned LANE_BITS = 7,
    parameter bit          REORDER   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 load,
    input  logic [LANE_BITS-1:0] par_in,
    output logic                 ser_out
);

    logic [LANE_BITS-1:0] image;
    logic [LANE_BITS-1:0] sh_q;

    generate
        if (REORDER) begin : g_reorder
            for (genvar p = 0; p < LANE_BITS; p++) begin : g_pos
                assign image[p] = par_in[src_bit(p, LANE_BITS)];
            end
        end else begin : g_straight
            assign image = par_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= image;
        end else begin
            sh_q <= {1'b0, sh_q[LANE_BITS-1:1]};
        end
    end

    assign ser_out = sh_q[0];

endmodule

// File: rtl/vser_top.sv
module vser_top
    import vser_pkg::*;
#(
    parameter int unsigned LANE_BITS      = DEF_LANE_BITS,
    parameter int unsigned NUM_DATA_LANES = DEF_DATA_LANES,
    localparam int unsigned WORD_BITS = LANE_BITS * NUM_DATA_LANES,
    localparam int unsigned SLOT_W    = $clog2(LANE_BITS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pd_n,
    input  logic                      cap_fall,
    input  logic                      pclk_in,
    input  logic [WORD_BITS-1:0]      pix_word,
    input  logic                      frame_stb,
    output logic [NUM_DATA_LANES-1:0] lane_data,
    output logic                      lane_clk
);

    localparam logic [31:0]          SHAPE_FULL = clk_shape(LANE_BITS);
    localparam logic [LANE_BITS-1:0] CLK_SHAPE  = SHAPE_FULL[LANE_BITS-1:0];

    logic [WORD_BITS-1:0] held_word;
    logic                 seq_load;
    logic [SLOT_W-1:0]    seq_slot;
    logic                 lanes_clr;

    assign lanes_clr = ~pd_n;

    vser_capture #(.WORD_BITS(WORD_BITS)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .cap_fall  (cap_fall),
        .pclk_in   (pclk_in),
        .word_in   (pix_word),
        .held_word (held_word)
    );

    vser_seq #(.LANE_BITS(LANE_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .frame_stb (frame_stb),
        .load      (seq_load),
        .slot      (seq_slot)
    );

    generate
        for (genvar k = 0; k < NUM_DATA_LANES; k++) begin : g_data
            vser_lane #(.LANE_BITS(LANE_BITS), .REORDER(1'b1)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .clr     (lanes_clr),
                .load    (seq_load),
                .par_in  (held_word[k*LANE_BITS +: LANE_BITS]),
                .ser_out (lane_data[k])
            );
        end
    endgenerate

    vser_lane #(.LANE_BITS(LANE_BITS), .REORDER(1'b0)) u_clk_lane (
        .clk     (clk),
        .rst     (rst),
        .clr     (lanes_clr),
        .load    (seq_load),
        .par_in  (CLK_SHAPE),
        .ser_out (lane_clk)
    );

endmodule

// File: rtl/vser_checker.sv
module vser_checker
    import vser_pkg::*;
#(
    parameter int unsigned LANE_BITS      = 7,
    parameter int unsigned NUM_DATA_LANES = 3,
    localparam int unsigned WORD_BITS = LANE_BITS * NUM_DATA_LANES,
    localparam int unsigned SLOT_W    = $clog2(LANE_BITS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      pd_n,
    input logic                      frame_stb,
    input logic                      load,
    input logic [SLOT_W-1:0]         slot,
    input logic [WORD_BITS-1:0]      held_word,
    input logic [NUM_DATA_LANES-1:0] lane_data,
    input logic                      lane_clk
);

    localparam int unsigned HI_SLOTS = (LANE_BITS + 1) / 2;
    localparam int unsigned FIRST    = src_bit(0, LANE_BITS);

    logic [SLOT_W-1:0]         cnt;
    logic                      valid;
    logic [NUM_DATA_LANES-1:0] first_bits;

    always_comb begin
        for (int k = 0; k < NUM_DATA_LANES; k++) begin
            first_bits[k] = held_word[k*LANE_BITS + FIRST];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            valid <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            cnt   <= '0;
        end else if (valid) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (lane_data == '0 && !lane_clk));

    p_first_slot_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (lane_data == $past(first_bits)));

    p_clk_shape_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (lane_clk == (int'(cnt) < HI_SLOTS)));

    p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && pd_n && int'(cnt) == LANE_BITS - 1) |-> load);

    p_slot_range_r5: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < LANE_BITS);

    p_pd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (lane_data == '0 && !lane_clk));

    p_stb_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && pd_n) |-> load);

    p_stb_slot0_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && pd_n) |=> (slot == '0));

endmodule

bind vser_top vser_checker #(
    .LANE_BITS      (LANE_BITS),
    .NUM_DATA_LANES (NUM_DATA_LANES)
) u_vser_checker (
    .clk       (clk),
    .rst       (rst),
    .pd_n      (pd_n),
    .frame_stb (frame_stb),
    .load      (seq_load),
    .slot      (seq_slot),
    .held_word (held_word),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
);

// File: tb/vser_top_bench.sv
module vser_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_n = 1'b1;
    logic        cap_fall = 1'b0;
    logic        pclk_in = 1'b0;
    logic [20:0] pix_word = '0;
    logic        frame_stb = 1'b0;
    logic [2:0]  lane_data;
    logic        lane_clk;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    bit          m_run;
    int          m_slot;
    logic [20:0] m_hold;
    logic [20:0] m_cur;
    bit          m_pq;
    int          ord [7] = '{1, 0, 6, 5, 4, 3, 2};

    // stimulus state
    int ph = 0;
    int wmode = 0;
    int walk = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vser_top u_vser_top (
        .clk       (clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .cap_fall  (cap_fall),
        .pclk_in   (pclk_in),
        .pix_word  (pix_word),
        .frame_stb (frame_stb),
        .lane_data (lane_data),
        .lane_clk  (lane_clk)
    );

    always @(posedge clk) begin
        bit cap;
        bit ld;
        if (rst) begin
            m_run = 0; m_slot = 0; m_hold = '0; m_cur = '0; m_pq = 0;
        end else begin
            cap = pd_n && (cap_fall ? (m_pq && !pclk_in) : (!m_pq && pclk_in));
            ld  = pd_n && (frame_stb || (m_run && m_slot == 6));
            if (!pd_n) begin
                m_run = 0; m_slot = 0;
            end else if (ld) begin
                m_run = 1; m_slot = 0; m_cur = m_hold;
            end else if (m_run) begin
                m_slot = m_slot + 1;
            end
            if (cap) m_hold = pix_word;
            m_pq = pclk_in;
        end
    end

    always @(negedge clk) begin
        logic [2:0] exp_d;
        logic       exp_c;
        if (!rst && !done) begin
            for (int k = 0; k < 3; k++) begin
                exp_d[k] = m_run ? m_cur[7*k + ord[m_slot]] : 1'b0;
            end
            exp_c = m_run && (m_slot < 4);
            checks++;
            if (lane_data !== exp_d || lane_clk !== exp_c) begin
                fails++;
                $display("FAIL %s slot=%0d data act=%b exp=%b clk act=%b exp=%b",
                         cur_req, m_slot, lane_data, exp_d, lane_clk, exp_c);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            ph = (ph + 1) % 7;
            pclk_in = (ph < 4);
            if (ph == 5) begin
                if (wmode == 0) begin
                    pix_word = 21'd1 << walk;
                    walk = (walk + 1) % 21;
                end else begin
                    pix_word = 21'($urandom);
                end
            end
        end
    endtask

    task automatic pulse_stb();
        frame_stb = 1'b1;
        tick(1);
        frame_stb = 1'b0;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (lane_data !== 3'b000 || lane_clk !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs act=%b%b exp=0000", lane_data, lane_clk);
        end
        @(posedge clk);
        #1;
        rst = 1'b0;

        cur_req = "R1";           // idle with no strobe
        tick(12);

        cur_req = "R2";           // walking one, rising capture
        wmode = 0;
        pulse_stb();
        tick(21 * 7 + 10);

        cur_req = "R3";           // random words
        wmode = 1;
        tick(70);

        cur_req = "R5";           // long back-to-back run, one strobe only
        tick(140);

        cur_req = "R6";           // falling-edge capture
        cap_fall = 1'b1;
        tick(70);
        wmode = 0;
        tick(70);
        wmode = 1;

        cur_req = "R8";           // mid-period strobes
        tick(3);
        pulse_stb();
        tick(11);
        pulse_stb();
        tick(30);

        cur_req = "R7";           // power-down, strobe ignored, idle after release
        pd_n = 1'b0;
        tick(6);
        pulse_stb();
        tick(10);
        pd_n = 1'b1;
        tick(20);
        pulse_stb();
        tick(40);
        cap_fall = 1'b0;
        tick(40);

        report();
    end

endmodule